// File: doc/BRIEF.md
# I2C Bus-Busy Monitor and Start/Stop Condition Generator

This block is the condition-control part of an I2C master. It samples the SDA and SCL lines, recognises start and stop conditions on the bus wherever they come from, and keeps a bus-busy flag that software can read. Software issues start, repeated-start and stop conditions by writing one 8-bit control register. The block then drives the line waveforms through open-drain output enables: an enable at 1 pulls the line low, and an enable at 0 releases it to the pull-up.

A mode input selects between I2C format and a clocked synchronous serial format. In the serial format the busy flag stays at 0 and no conditions are detected or generated. The same register also lets software set the SDA output level directly when no condition is being generated. Byte shifting, acknowledge, arbitration and clock division belong to other blocks.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset the register reads 0x60 (busy 0, qualifier 1, SDA level 1, error 0), and both sda_oe_o and scl_oe_o are 0.
- R2: In I2C mode, a falling SDA while SCL stays high sets the busy flag (register bit 7) within 4 clock cycles.
- R3: In I2C mode, a rising SDA while SCL stays high clears the busy flag within 4 clock cycles.
- R4: An SDA edge while SCL is low leaves the busy flag unchanged.
- R5: A write with bit 7 = 1 and bit 6 = 0 from the idle bus releases both lines for SETUP_CYC cycles. It then pulls SDA low with SCL released for HOLD_CYC cycles, and then holds both lines low.
- R6: The same write while the block is holding SCL low produces a repeated start. SDA is released while SCL stays low, then SCL is released, and the R5 start follows. At the end both lines are held low and busy stays 1.
- R7: A write with bit 7 = 0 and bit 6 = 0 issues a stop. Both lines are held low for SETUP_CYC cycles, then SCL is released for SETUP_CYC cycles with SDA low, and then SDA is released. Busy then reads 0.
- R8: Bit 6 (qualifier) always reads 1. A write with bit 6 = 1 generates no condition and leaves the busy flag unchanged.
- R9: A write with bit 6 = 1 sets the SDA level from bit 5: 0 pulls SDA low (sda_oe_o = 1) and 1 releases it. Bit 5 always reads back the present SDA output level, including after a generated condition.
- R10: With mode_sync_i = 1 the busy flag reads 0, bus edges are ignored and condition writes generate nothing.
- R11: A condition write that arrives while a generated condition is in progress is discarded and sets bit 4, a sticky error flag that stays set until reset.
- R12: Register bits 3 to 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sync_i | input | 1 | 1 = clocked synchronous serial format, 0 = I2C format |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| sda_i | input | 1 | Sampled SDA line level |
| scl_i | input | 1 | Sampled SCL line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |

## Verification
The busy-flag assertions assume that SDA and SCL never change within the same synchronised sample. When both change in one sample, the edge detector cannot tell the order of the edges. The bench models the lines as wired-AND of the block's enables and its own pull-downs, and it moves one line at a time, several cycles apart. The mode input is changed only while no generated condition is in progress.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  localparam int REG_W    = 8;
  localparam int BUSY_BIT = 7;
  localparam int QUAL_BIT = 6;
  localparam int SDA_BIT  = 5;
  localparam int ERR_BIT  = 4;

  typedef enum logic [2:0] {
    G_IDLE,
    G_RS_SDA,   // SDA released, SCL still low
    G_RS_SCL,   // both released, setup before start
    G_ST_HOLD,  // SDA low, SCL high: start hold
    G_SP_LOW,   // both low before stop
    G_SP_SCL    // SCL released, SDA low: stop setup
  } gen_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = din;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sda_s_i,
  input  logic scl_s_i,
  output logic start_seen_o,
  output logic stop_seen_o
);

  logic sda_prev_q, scl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q <= 1'b1;
      scl_prev_q <= 1'b1;
    end else begin
      sda_prev_q <= sda_s_i;
      scl_prev_q <= scl_s_i;
    end
  end

  logic scl_held_high;
  assign scl_held_high = scl_s_i && scl_prev_q;
  assign start_seen_o  = en_i && scl_held_high && sda_prev_q && !sda_s_i;
  assign stop_seen_o   = en_i && scl_held_high && !sda_prev_q && sda_s_i;

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int HOLD_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic sda_wr_i,
  input  logic sda_val_i,
  output logic sda_drv_o,
  output logic scl_drv_o,
  output logic active_o
);

  localparam int MAXC  = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  gen_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sda_drv_q, sda_drv_d;
  logic             scl_drv_q, scl_drv_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    sda_drv_d = sda_drv_q;
    scl_drv_d = scl_drv_q;
    unique case (state_q)
      G_IDLE: begin
        if (start_i) begin
          cnt_d     = SETUP_LD;
          sda_drv_d = 1'b0;
          state_d   = scl_drv_q ? G_RS_SDA : G_RS_SCL;
        end else if (stop_i) begin
          cnt_d     = SETUP_LD;
          sda_drv_d = 1'b1;
          scl_drv_d = 1'b1;
          state_d   = G_SP_LOW;
        end else if (sda_wr_i) begin
          sda_drv_d = !sda_val_i;
        end
      end
      G_RS_SDA: begin
        if (cnt_zero) begin
          cnt_d     = SETUP_LD;
          scl_drv_d = 1'b0;
          state_d   = G_RS_SCL;
        end else cnt_d = cnt_q - 1'b1;
      end
      G_RS_SCL: begin
        if (cnt_zero) begin
          cnt_d     = HOLD_LD;
          sda_drv_d = 1'b1;
          state_d   = G_ST_HOLD;
        end else cnt_d = cnt_q - 1'b1;
      end
      G_ST_HOLD: begin
        if (cnt_zero) begin
          scl_drv_d = 1'b1;
          state_d   = G_IDLE;
        end else cnt_d = cnt_q - 1'b1;
      end
      G_SP_LOW: begin
        if (cnt_zero) begin
          cnt_d     = SETUP_LD;
          scl_drv_d = 1'b0;
          state_d   = G_SP_SCL;
        end else cnt_d = cnt_q - 1'b1;
      end
      G_SP_SCL: begin
        if (cnt_zero) begin
          sda_drv_d = 1'b0;
          state_d   = G_IDLE;
        end else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = G_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= G_IDLE;
      cnt_q     <= '0;
      sda_drv_q <= 1'b0;
      scl_drv_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      sda_drv_q <= sda_drv_d;
      scl_drv_q <= scl_drv_d;
    end
  end

  assign sda_drv_o = sda_drv_q;
  assign scl_drv_o = scl_drv_q;
  assign active_o  = (state_q != G_IDLE);

  // R5
  scl_pull_after_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drv_q) |-> sda_drv_q);

  // R7
  stop_sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_drv_q) && $past(state_q) == G_SP_SCL) |-> !scl_drv_q);

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
#(
  parameter int SETUP_CYC   = 4,
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sync_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             sda_i,
  input  logic             scl_i,
  output logic             sda_oe_o,
  output logic             scl_oe_o
);

  logic [1:0] lines_s;
  logic       sda_s, scl_s;
  logic       start_seen, stop_seen;
  logic       gen_active, sda_drv, scl_drv;
  logic       busy_q, busy_d;
  logic       err_q, err_d;
  logic       cmd_valid, cmd_accept, sda_wr;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_i, sda_i}),
    .dout (lines_s)
  );
  assign sda_s = lines_s[0];
  assign scl_s = lines_s[1];

  i2c_cond_detect u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (!mode_sync_i),
    .sda_s_i     (sda_s),
    .scl_s_i     (scl_s),
    .start_seen_o(start_seen),
    .stop_seen_o (stop_seen)
  );

  assign cmd_valid  = wr_en_i && !wr_data_i[QUAL_BIT] && !mode_sync_i;
  assign cmd_accept = cmd_valid && !gen_active;
  assign sda_wr     = wr_en_i && wr_data_i[QUAL_BIT];

  i2c_cond_gen #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (cmd_accept && wr_data_i[BUSY_BIT]),
    .stop_i   (cmd_accept && !wr_data_i[BUSY_BIT]),
    .sda_wr_i (sda_wr),
    .sda_val_i(wr_data_i[SDA_BIT]),
    .sda_drv_o(sda_drv),
    .scl_drv_o(scl_drv),
    .active_o (gen_active)
  );

  always_comb begin
    busy_d = busy_q;
    if (mode_sync_i)     busy_d = 1'b0;
    else if (start_seen) busy_d = 1'b1;
    else if (stop_seen)  busy_d = 1'b0;
    err_d = err_q || (cmd_valid && gen_active);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[BUSY_BIT] = busy_q;
    rd_data_o[QUAL_BIT] = 1'b1;
    rd_data_o[SDA_BIT]  = !sda_drv;
    rd_data_o[ERR_BIT]  = err_q;
  end

  assign sda_oe_o = sda_drv;
  assign scl_oe_o = scl_drv;

  // R11
  cmd_busy_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && gen_active) |=> err_q);

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && !mode_sync_i) |=> busy_q);

  // R3
  stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !mode_sync_i) |=> !busy_q);

  // R10
  sync_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sync_i |=> !busy_q);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: tb/i2c_cond_ctrl_bench.sv
module i2c_cond_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_sync;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       sda_oe, scl_oe;
  logic       ext_sda_low, ext_scl_low;
  logic       sda_line, scl_line;

  always #2 clk = ~clk;

  assign sda_line = !(sda_oe || ext_sda_low);
  assign scl_line = !(scl_oe || ext_scl_low);

  i2c_cond_ctrl u_i2c_cond_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sync_i(mode_sync),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .sda_i      (sda_line),
    .scl_i      (scl_line),
    .sda_oe_o   (sda_oe),
    .scl_oe_o   (scl_oe)
  );

  typedef struct {
    logic [7:0] rd;
    logic       sda;
    logic       scl;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   compared   = 0;
  int   mismatched = 0;
  bit   done       = 0;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_now(input logic [7:0] rd, input logic sda, input logic scl,
                            input string req);
    exp_t e;
    e.rd = rd; e.sda = sda; e.scl = scl; e.req = req;
    exp_q.push_back(e);
    @(negedge clk);
    #0.1;
  endtask

  task automatic reg_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // monitor: pops one expected item each negedge and compares
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compared++;
        if (rd_data !== e.rd || sda_oe !== e.sda || scl_oe !== e.scl) begin
          mismatched++;
          $display("FAIL %s: rd=%h sda_oe=%b scl_oe=%b, expected rd=%h sda_oe=%b scl_oe=%b",
                   e.req, rd_data, sda_oe, scl_oe, e.rd, e.sda, e.scl);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_sync = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    ext_sda_low = 1'b0; ext_scl_low = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 R12 reset state
    expect_now(8'h60, 1'b0, 1'b0, "R1");

    // R2 external start
    ext_sda_low = 1'b1; tick(6);
    expect_now(8'hE0, 1'b0, 1'b0, "R2");

    // R4 SDA rises while SCL low: busy stays
    ext_scl_low = 1'b1; tick(4);
    ext_sda_low = 1'b0; tick(6);
    expect_now(8'hE0, 1'b0, 1'b0, "R4");

    // R3 external stop
    ext_sda_low = 1'b1; tick(4);
    ext_scl_low = 1'b0; tick(4);
    ext_sda_low = 1'b0; tick(6);
    expect_now(8'h60, 1'b0, 1'b0, "R3");

    // R9 R8 direct SDA control (SCL held low externally)
    ext_scl_low = 1'b1; tick(4);
    reg_write(8'h40);
    expect_now(8'h40, 1'b1, 1'b0, "R9");
    reg_write(8'hC0); tick(10);
    expect_now(8'h40, 1'b1, 1'b0, "R8");
    reg_write(8'h60);
    expect_now(8'h60, 1'b0, 1'b0, "R9");
    ext_scl_low = 1'b0; tick(6);

    // R5 start from idle: mid-hold then final
    reg_write(8'h80); tick(5);
    expect_now(8'h40, 1'b1, 1'b0, "R5");
    tick(20);
    expect_now(8'hC0, 1'b1, 1'b1, "R5");

    // R6 repeated start, R11 stop during it is discarded
    reg_write(8'h80); tick(1);
    expect_now(8'hE0, 1'b0, 1'b1, "R6");
    reg_write(8'h00); tick(30);
    expect_now(8'hD0, 1'b1, 1'b1, "R6 R11");

    // R7 stop
    reg_write(8'h00); tick(5);
    expect_now(8'hD0, 1'b1, 1'b0, "R7");
    tick(20);
    expect_now(8'h70, 1'b0, 1'b0, "R7");

    // R10 sync mode: no detection, no generation
    mode_sync = 1'b1; tick(2);
    ext_sda_low = 1'b1; tick(6);
    expect_now(8'h70, 1'b0, 1'b0, "R10");
    ext_sda_low = 1'b0; tick(4);
    reg_write(8'h80); tick(10);
    expect_now(8'h70, 1'b0, 1'b0, "R10");

    // R2 in I2C mode again, then R10 busy forced clear
    mode_sync = 1'b0; tick(2);
    ext_sda_low = 1'b1; tick(6);
    expect_now(8'hF0, 1'b0, 1'b0, "R2");
    mode_sync = 1'b1; tick(2);
    expect_now(8'h70, 1'b0, 1'b0, "R10");
    ext_sda_low = 1'b0; tick(4);

    tick(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule